// File: doc/BRIEF.md
# Dual Split-Stage Decade Counter

This block holds two independent four-bit counter halves. Each half is not a single modulo-10 counter. It is two sub-counters: a divide-by-two stage and a divide-by-five stage. Each stage has its own count input and advances when that input goes from high to low. The four stage bits of each half are brought out in parallel, so every sub-multiple of the count rate can be picked off directly.

The counting mode is chosen by wiring outside the block. Feed the divide-by-two output into the divide-by-five count input and the half counts in BCD, 0 through 9. Feed the top divide-by-five bit into the divide-by-two count input and the half counts bi-quinary. In that mode the divide-by-two bit is a square wave at one tenth of the input rate with an even duty cycle. Feeding the top bit of one half into the other half's count input chains the two halves, for division ratios up to 100.

Everything runs on one system clock. Count inputs are sampled on that clock and compared with their previous sample, so a stage output that changes on one cycle reaches the stage it drives one cycle later. Each half has its own asynchronous clear.

Top module: `dbq_dual_counter`

## Requirements
- R1: After the system reset is released, every bit of `q` reads 0.
- R2: The divide-by-two bit of a half (bit 4h) toggles once for each high-to-low transition of `cnt2_in[h]`. It shows the new value in the cycle after the low level is first sampled. A rising transition or a steady level leaves it unchanged.
- R3: The divide-by-five field of a half (bits 4h+3..4h+1, LSB at 4h+1) steps 0,1,2,3,4 in binary on each falling transition of `cnt5_in[h]`, then returns to 0. It never holds a value above 4.
- R4: The two stages of a half are independent: edges on one count input never change the other stage's bits.
- R5: `clr[h]` is active high and asynchronous. It zeroes all four bits of half h without waiting for a clock edge. While it is held, falling edges on that half's count inputs have no effect.
- R6: `clr[h]` leaves the other half's bits unchanged.
- R7: With bit 4h wired to `cnt5_in[h]` and pulses applied to `cnt2_in[h]`, the half's field q[4h+3:4h] reads the pulse count modulo 10 in BCD.
- R8: With bit 4h+3 wired to `cnt2_in[h]` and pulses applied to `cnt5_in[h]`, bit 4h is high for five input pulses and then low for five.
- R9: Every link in a wired chain adds one system-clock cycle. In BCD mode the 9-to-0 step first reads 8 for one cycle and reads 0 one cycle later.
- R10: With both halves in BCD mode and half 0's bit 3 driving `cnt2_in[1]`, the eight bits read the pulse count modulo 100 as two BCD digits, tens in half 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all count inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released through a two-flop synchronizer |
| clr | input | NUM_HALVES | Per-half asynchronous clear, active high |
| cnt2_in | input | NUM_HALVES | Per-half count input of the divide-by-two stage, counts on falling transitions |
| cnt5_in | input | NUM_HALVES | Per-half count input of the divide-by-five stage, counts on falling transitions |
| q | output | 4*NUM_HALVES | Stage bits; for half h: bit 4h divide-by-two, bits 4h+3..4h+1 divide-by-five (LSB at 4h+1) |

## Verification
The bench targets the wrap points. A divide-by-five stage that let 5 through, or that wrapped at 4, would break both the BCD sequence and the five-high, five-low square wave. The bench times the 9-to-0 step cycle by cycle, so an extra register in the ripple path, or a stage that reacted on the rising edge, would show the wrong intermediate value. Clear is checked between clock edges and again while count edges arrive. A clear that waited for the clock, that leaked into the other half, or that let an edge through would show up as a nonzero field. The chained test runs past 100 pulses, so a lost or doubled carry between the halves shows up as a wrong tens digit.

// File: rtl/dbq_pkg.sv
package dbq_pkg;
  localparam int unsigned LO_MOD = 2;
  localparam int unsigned HI_MOD = 5;
  localparam int unsigned LO_W   = $clog2(LO_MOD);
  localparam int unsigned HI_W   = $clog2(HI_MOD);
  localparam int unsigned HALF_W = LO_W + HI_W;

  typedef logic [HALF_W-1:0] half_q_t;
endpackage

// File: rtl/dbq_fall_det.sv
module dbq_fall_det #(
  parameter int unsigned SYNC_DEPTH = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_in,
  output logic fall_o
);
  logic smp;
  logic prev_q;

  generate
    if (SYNC_DEPTH == 0) begin : g_direct
      assign smp = lvl_in;
    end else begin : g_sync
      logic [SYNC_DEPTH-1:0] sync_q;
      for (genvar i = 0; i < SYNC_DEPTH; i++) begin : g_flop
        logic d;
        if (i == 0) begin : g_first
          assign d = lvl_in;
        end else begin : g_rest
          assign d = sync_q[i-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= d;
        end
      end
      assign smp = sync_q[SYNC_DEPTH-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= smp;
  end

  assign fall_o = prev_q & ~smp;
endmodule

// File: rtl/dbq_mod_stage.sv
module dbq_mod_stage #(
  parameter int unsigned MODULUS = 5,
  parameter int unsigned W       = (MODULUS > 1) ? $clog2(MODULUS) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] LAST = W'(MODULUS - 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_nxt;
  logic         cnt_en;

  assign cnt_en = adv_i;

  always_comb begin
    cnt_nxt = cnt_q;
    if (cnt_en) begin
      if (cnt_q == LAST) cnt_nxt = '0;
      else               cnt_nxt = cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n or posedge clr) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nxt;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dbq_half.sv
module dbq_half
  import dbq_pkg::*;
#(
  parameter int unsigned SYNC_DEPTH = 0
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    clr,
  input  logic    cnt2_in,
  input  logic    cnt5_in,
  output half_q_t q
);
  logic            lo_fall;
  logic            hi_fall;
  logic [LO_W-1:0] lo_cnt;
  logic [HI_W-1:0] hi_cnt;

  dbq_fall_det #(.SYNC_DEPTH(SYNC_DEPTH)) u_lo_det (
    .clk(clk), .rst_n(rst_n), .lvl_in(cnt2_in), .fall_o(lo_fall)
  );

  dbq_fall_det #(.SYNC_DEPTH(SYNC_DEPTH)) u_hi_det (
    .clk(clk), .rst_n(rst_n), .lvl_in(cnt5_in), .fall_o(hi_fall)
  );

  dbq_mod_stage #(.MODULUS(LO_MOD), .W(LO_W)) u_lo (
    .clk(clk), .rst_n(rst_n), .clr(clr), .adv_i(lo_fall), .cnt_o(lo_cnt)
  );

  dbq_mod_stage #(.MODULUS(HI_MOD), .W(HI_W)) u_hi (
    .clk(clk), .rst_n(rst_n), .clr(clr), .adv_i(hi_fall), .cnt_o(hi_cnt)
  );

  assign q = {hi_cnt, lo_cnt};
endmodule

// File: rtl/dbq_dual_counter.sv
module dbq_dual_counter
  import dbq_pkg::*;
#(
  parameter int unsigned NUM_HALVES = 2,
  parameter int unsigned SYNC_DEPTH = 0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_HALVES-1:0]        clr,
  input  logic [NUM_HALVES-1:0]        cnt2_in,
  input  logic [NUM_HALVES-1:0]        cnt5_in,
  output logic [HALF_W*NUM_HALVES-1:0] q
);
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end

  assign rst_int_n = rst_pipe[1];

  generate
    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
      half_q_t hq;
      dbq_half #(.SYNC_DEPTH(SYNC_DEPTH)) u_half (
        .clk(clk), .rst_n(rst_int_n), .clr(clr[h]),
        .cnt2_in(cnt2_in[h]), .cnt5_in(cnt5_in[h]), .q(hq)
      );
      assign q[HALF_W*h +: HALF_W] = hq;
    end
  endgenerate
endmodule

// File: rtl/dbq_dual_counter_chk.sv
module dbq_dual_counter_chk #(
  parameter int unsigned NUM_HALVES = 2,
  parameter int unsigned SYNC_DEPTH = 0
) (
  input logic                    clk,
  input logic                    rst_int_n,
  input logic [NUM_HALVES-1:0]   clr,
  input logic [NUM_HALVES-1:0]   cnt2_in,
  input logic [NUM_HALVES-1:0]   cnt5_in,
  input logic [4*NUM_HALVES-1:0] q
);
  generate
    for (genvar g = 0; g < NUM_HALVES; g++) begin : g_chk
      AST_DIV5_RANGE: assert property (@(posedge clk) disable iff (!rst_int_n)
        q[4*g+3 -: 3] <= 3'd4);                                          // R3
      AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
        clr[g] |-> q[4*g+3 -: 4] == 4'd0);                               // R5
      if (SYNC_DEPTH == 0) begin : g_timed
        AST_DIV2_STEP: assert property (@(posedge clk) disable iff (!rst_int_n)
          ($past(rst_int_n) && $fell(cnt2_in[g]) && !clr[g])
          |=> (clr[g] || q[4*g] != $past(q[4*g])));                      // R2
        AST_DIV2_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
          !$fell(cnt2_in[g]) |=> (clr[g] || $stable(q[4*g])));           // R4
        AST_DIV5_STEP: assert property (@(posedge clk) disable iff (!rst_int_n)
          ($past(rst_int_n) && $fell(cnt5_in[g]) && !clr[g])
          |=> (clr[g] || q[4*g+3 -: 3] ==
               (($past(q[4*g+3 -: 3]) == 3'd4) ? 3'd0
                : $past(q[4*g+3 -: 3]) + 3'd1)));                        // R3
        AST_DIV5_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
          !$fell(cnt5_in[g]) |=> (clr[g] || $stable(q[4*g+3 -: 3])));    // R4
      end
    end
  endgenerate
endmodule

bind dbq_dual_counter dbq_dual_counter_chk #(
  .NUM_HALVES(NUM_HALVES), .SYNC_DEPTH(SYNC_DEPTH)
) u_chk (
  .clk(clk), .rst_int_n(rst_int_n), .clr(clr),
  .cnt2_in(cnt2_in), .cnt5_in(cnt5_in), .q(q)
);

// File: tb/dbq_dual_counter_test.sv
module dbq_dual_counter_test;
  logic       clk;
  logic       rst_n;
  logic [1:0] clr;
  logic [1:0] drv2, drv5;
  logic [1:0] c2, c5;
  logic [7:0] q;
  logic       bcd0, bcd1, biq1, casc;
  int         n_chk, n_fail;

  assign c2[0] = drv2[0];
  assign c5[0] = bcd0 ? q[0] : drv5[0];
  assign c2[1] = casc ? q[3] : (biq1 ? q[7] : drv2[1]);
  assign c5[1] = bcd1 ? q[4] : drv5[1];

  dbq_dual_counter uut (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .cnt2_in(c2), .cnt5_in(c5), .q(q)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic pulse(input bit five, input int h);
    @(negedge clk);
    if (five) drv5[h] = 1'b0; else drv2[h] = 1'b0;
    repeat (6) @(negedge clk);
    if (five) drv5[h] = 1'b1; else drv2[h] = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic set_mode(input logic b0, input logic b1, input logic bq, input logic cs);
    @(negedge clk);
    clr = 2'b11;
    bcd0 = b0; bcd1 = b1; biq1 = bq; casc = cs;
    repeat (2) @(negedge clk);
    clr = 2'b00;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 q after reset", int'(q), 0);
  endtask

  task automatic t_div2();
    pulse(1'b0, 0);
    check("R2 toggle to 1", int'(q[0]), 1);
    check("R4 div5 untouched by div2", int'(q[3:1]), 0);
    repeat (4) @(negedge clk);
    check("R2 no change on rising/steady", int'(q[0]), 1);
    pulse(1'b0, 0);
    check("R2 toggle to 0", int'(q[0]), 0);
    @(negedge clk); drv2[0] = 1'b0;
    @(negedge clk);
    check("R2 one cycle after low sampled", int'(q[0]), 1);
    repeat (3) @(negedge clk); drv2[0] = 1'b1;
    repeat (2) @(negedge clk);
    pulse(1'b0, 0);
    check("R2 back to 0", int'(q[0]), 0);
  endtask

  task automatic t_div5();
    pulse(1'b0, 0);
    for (int n = 1; n <= 7; n++) begin
      pulse(1'b1, 0);
      check("R3 div5 sequence", int'(q[3:1]), n % 5);
      check("R4 div2 untouched by div5", int'(q[0]), 1);
    end
  endtask

  task automatic t_clear();
    set_mode(1'b0, 1'b0, 1'b0, 1'b0);
    pulse(1'b1, 1); pulse(1'b1, 1);
    pulse(1'b1, 0); pulse(1'b0, 0);
    check("R3 setup half0", int'(q[3:0]), 3);
    @(negedge clk);
    clr[0] = 1'b1;
    #1;
    check("R5 async clear before edge", int'(q[3:0]), 0);
    check("R6 other half kept", int'(q[7:4]), 4);
    pulse(1'b0, 0); pulse(1'b1, 0);
    check("R5 edges ignored under clear", int'(q[3:0]), 0);
    clr[0] = 1'b0;
    repeat (2) @(negedge clk);
    check("R5 no count on release", int'(q[3:0]), 0);
    check("R6 other half still kept", int'(q[7:4]), 4);
    pulse(1'b0, 0);
    check("R5 counts after release", int'(q[3:0]), 1);
  endtask

  task automatic t_bcd();
    set_mode(1'b1, 1'b0, 1'b0, 1'b0);
    for (int n = 1; n <= 12; n++) begin
      pulse(1'b0, 0);
      check("R7 BCD count", int'(q[3:0]), n % 10);
    end
  endtask

  task automatic t_ripple();
    set_mode(1'b1, 1'b0, 1'b0, 1'b0);
    for (int n = 1; n <= 9; n++) pulse(1'b0, 0);
    check("R7 at nine", int'(q[3:0]), 9);
    @(negedge clk); drv2[0] = 1'b0;
    @(negedge clk);
    check("R9 first link only", int'(q[3:0]), 8);
    @(negedge clk);
    check("R9 second link one cycle later", int'(q[3:0]), 0);
    repeat (4) @(negedge clk); drv2[0] = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_biq();
    set_mode(1'b0, 1'b0, 1'b1, 1'b0);
    for (int n = 1; n <= 20; n++) begin
      pulse(1'b1, 1);
      check("R8 square wave bit", int'(q[4]), (n / 5) % 2);
      check("R8 quinary field", int'(q[7:5]), n % 5);
    end
  endtask

  task automatic t_cascade();
    set_mode(1'b1, 1'b1, 1'b0, 1'b1);
    for (int n = 1; n <= 105; n++) begin
      pulse(1'b0, 0);
      check("R10 cascade", int'(q), ((n % 100) / 10) * 16 + (n % 10));
    end
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; clr = 2'b00; drv2 = 2'b11; drv5 = 2'b11;
    bcd0 = 1'b0; bcd1 = 1'b0; biq1 = 1'b0; casc = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_div2();
    t_div5();
    t_clear();
    t_bcd();
    t_ripple();
    t_biq();
    t_cascade();
    summary();
  end
endmodule